// File: doc/BRIEF.md
# DMA Channel Trigger and Chaining Hub

This block decides when each DMA channel and each quick-DMA channel is triggered, and hands the triggered channel numbers, one per cycle, to a downstream scheduler. A DMA channel can be triggered in three ways:

- software writes a 1 to its bit in a manual-trigger register;
- a hardware event pulse arrives on its line of the event input;
- a completion report names it as a chained successor, so that one event can drive a series of transfers.

A quick-DMA channel is triggered when software writes one chosen word of that channel's parameter set. Each channel has a selector that picks which word arms it. Address generation and the data path are handled elsewhere.

Completion reports also set interrupt-pending bits. The completion interrupt is raised from the pending bits that are enabled. A trigger that lands on a channel which is still waiting to be dispatched is not counted twice. Instead it sets a sticky missed-trigger flag, and any such flag raises an error interrupt.

Registers are written through a simple write port. The address is `{group[2:0], word}`, where `word` selects a 32-channel slice. With 64 channels `word` is one bit, so the address is 4 bits.

Top module: `dma_trig_hub`

## Requirements
- R1: After reset, `disp_valid`, `int_pend`, `miss_err`, `qmiss_err`, `irq` and `err_irq` are all zero, event enables and interrupt enables are zero, and every quick-DMA word selector holds 7.
- R2: Writing group 0 (manual trigger) at word w with data bit b set triggers DMA channel 32*w+b. A trigger captured at clock edge k appears on `disp_valid`/`disp_ch` with `disp_qdma`=0 after edge k+1, and is dispatched exactly once.
- R3: An event pulse on `evt_i[c]` is always latched. It is dispatched only while the event-enable bit of channel c (group 1, word c/32, bit c%32) is 1, and a latched event on a disabled channel is dispatched once its enable is later set.
- R4: A completion report (`cmpl_valid`=1) with `cmpl_chain_en`=1 triggers DMA channel `cmpl_code`. With `cmpl_chain_en`=0 it triggers nothing.
- R5: When several DMA channels are pending, one channel is dispatched per cycle, lowest channel number first.
- R6: A pending quick-DMA channel is dispatched (`disp_qdma`=1, `disp_ch`=quick channel number) only in a cycle with no pending DMA channel. Among quick channels the lowest number goes first.
- R7: A write strobe `qwr_valid` with `qwr_ch`=q and `qwr_word`=w triggers quick channel q only when w equals q's selector, which is bits [3q+2:3q] of group 5, word 0. Writes to other words are ignored.
- R8: A trigger on a channel that is still pending and not being dispatched in that cycle sets a sticky bit, `miss_err[c]` or `qmiss_err[q]`. The bit is cleared only by writing 1 to it (group 4 for DMA channels, group 6 word 0 for quick channels). `err_irq` is the OR of all these bits.
- R9: A completion report with `cmpl_int_en`=1 sets `int_pend[cmpl_code]`. Writing 1 to group 3 clears pending bits, and a set in the same cycle wins. `irq` is high when any pending bit has its enable set (group 2).
- R10: A trigger that arrives in the very cycle its channel is dispatched re-arms the channel for another dispatch and does not set a missed-trigger bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | `{group, word}` register address |
| reg_wdata | input | 32 | Register write data |
| evt_i | input | 64 | Per-channel hardware event pulses |
| qwr_valid | input | 1 | Quick-DMA parameter-set word write strobe |
| qwr_ch | input | 3 | Quick channel whose parameter set is written |
| qwr_word | input | 3 | Word index written within the parameter set |
| cmpl_valid | input | 1 | Completion report strobe |
| cmpl_code | input | 6 | Completion code: interrupt bit and chain target |
| cmpl_int_en | input | 1 | Completion report sets an interrupt-pending bit |
| cmpl_chain_en | input | 1 | Completion report triggers channel `cmpl_code` |
| disp_valid | output | 1 | A channel is being dispatched this cycle |
| disp_qdma | output | 1 | Dispatched channel is a quick-DMA channel |
| disp_ch | output | 6 | Dispatched channel number |
| int_pend | output | 64 | Completion interrupt-pending bits |
| irq | output | 1 | Completion interrupt |
| miss_err | output | 64 | Sticky missed-trigger bits, DMA channels |
| qmiss_err | output | 8 | Sticky missed-trigger bits, quick channels |
| err_irq | output | 1 | Error interrupt |

## Verification
Each trigger source is swept across every channel it can reach, one channel at a time: manual bits, enabled events, chained completions and quick-channel words. These single-channel sweeps separate decoding errors (wrong word, bit or code) from timing errors. Multi-bit manual writes and simultaneous DMA and quick-DMA triggers show the dispatch order, and so distinguish lowest-first from any other ordering and DMA-first from quick-first. Back-to-back triggers on a blocked channel, and on a channel being dispatched, tell a real miss apart from a legal re-arm. Set/clear collisions on the interrupt bits show which side wins.

// File: rtl/dth_pkg.sv
package dth_pkg;

   localparam int GRP_W = 3;

   typedef enum logic [GRP_W-1:0] {
      GRP_MAN_SET   = 3'd0,
      GRP_EVT_EN    = 3'd1,
      GRP_INT_EN    = 3'd2,
      GRP_INT_CLR   = 3'd3,
      GRP_MISS_CLR  = 3'd4,
      GRP_QSEL      = 3'd5,
      GRP_QMISS_CLR = 3'd6,
      GRP_RSVD      = 3'd7
   } reg_grp_e;

   typedef enum int {
      PICK_LOOP    = 0,
      PICK_ISOLATE = 1
   } pick_style_e;

endpackage

// File: rtl/dth_lowest.sv
module dth_lowest #(
   parameter int N     = 64,
   parameter int STYLE = 0,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     vec,
   output logic             any,
   output logic [IDX_W-1:0] idx,
   output logic [N-1:0]     onehot
);
   import dth_pkg::*;

   assign any = |vec;

   generate
      if (STYLE == PICK_ISOLATE) begin : g_isolate
         assign onehot = vec & (~vec + N'(1));
         always_comb begin
            idx = '0;
            for (int i = 0; i < N; i++) begin
               if (onehot[i]) idx = idx | IDX_W'(i);
            end
         end
      end else begin : g_loop
         always_comb begin
            idx = '0;
            for (int i = N - 1; i >= 0; i--) begin
               if (vec[i]) idx = IDX_W'(i);
            end
         end
         always_comb begin
            onehot      = '0;
            onehot[idx] = any;
         end
      end
   endgenerate

endmodule

// File: rtl/dth_slot.sv
module dth_slot (
   input  logic clk,
   input  logic rst_n,
   input  logic src_gated,
   input  logic src_direct,
   input  logic gate_en,
   input  logic take,
   input  logic miss_clr,
   output logic req,
   output logic miss
);
   logic lat_gated;
   logic lat_direct;
   logic busy;
   logic arrive;

   assign busy   = lat_gated | lat_direct;
   assign arrive = src_gated | src_direct;
   assign req    = (lat_gated & gate_en) | lat_direct;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lat_gated  <= 1'b0;
         lat_direct <= 1'b0;
         miss       <= 1'b0;
      end else begin
         lat_gated  <= src_gated  | (lat_gated  & ~take);
         lat_direct <= src_direct | (lat_direct & ~take);
         miss       <= (arrive & busy & ~take) | (miss & ~miss_clr);
      end
   end

endmodule

// File: rtl/dth_regs.sv
module dth_regs #(
   parameter int NUM_CH     = 64,
   parameter int NUM_QCH    = 8,
   parameter int DATA_W     = 32,
   parameter int PSET_WORDS = 8,
   localparam int WORDS  = NUM_CH / DATA_W,
   localparam int WORD_W = (WORDS > 1) ? $clog2(WORDS) : 1,
   localparam int ADDR_W = dth_pkg::GRP_W + WORD_W,
   localparam int QW_W   = $clog2(PSET_WORDS)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      reg_wr,
   input  logic [ADDR_W-1:0]         reg_addr,
   input  logic [DATA_W-1:0]         reg_wdata,
   output logic [NUM_CH-1:0]         man_trig,
   output logic [NUM_CH-1:0]         evt_en,
   output logic [NUM_CH-1:0]         int_en,
   output logic [NUM_CH-1:0]         int_clr,
   output logic [NUM_CH-1:0]         miss_clr,
   output logic [NUM_QCH*QW_W-1:0]   qsel,
   output logic [NUM_QCH-1:0]        qmiss_clr
);
   import dth_pkg::*;

   reg_grp_e          grp;
   logic [WORD_W-1:0] wsel;
   logic              hit0;

   assign grp  = reg_grp_e'(reg_addr[ADDR_W-1 -: GRP_W]);
   assign wsel = reg_addr[WORD_W-1:0];
   assign hit0 = reg_wr && (wsel == '0);

   genvar w;
   generate
      for (w = 0; w < WORDS; w++) begin : g_word
         logic hit;
         assign hit = reg_wr && (wsel == WORD_W'(w));

         assign man_trig[w*DATA_W +: DATA_W] = (hit && grp == GRP_MAN_SET)  ? reg_wdata : '0;
         assign int_clr [w*DATA_W +: DATA_W] = (hit && grp == GRP_INT_CLR)  ? reg_wdata : '0;
         assign miss_clr[w*DATA_W +: DATA_W] = (hit && grp == GRP_MISS_CLR) ? reg_wdata : '0;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               evt_en[w*DATA_W +: DATA_W] <= '0;
               int_en[w*DATA_W +: DATA_W] <= '0;
            end else if (hit) begin
               if (grp == GRP_EVT_EN) evt_en[w*DATA_W +: DATA_W] <= reg_wdata;
               if (grp == GRP_INT_EN) int_en[w*DATA_W +: DATA_W] <= reg_wdata;
            end
         end
      end
   endgenerate

   assign qmiss_clr = (hit0 && grp == GRP_QMISS_CLR) ? reg_wdata[NUM_QCH-1:0] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int q = 0; q < NUM_QCH; q++) qsel[q*QW_W +: QW_W] <= QW_W'(PSET_WORDS - 1);
      end else if (hit0 && grp == GRP_QSEL) begin
         qsel <= reg_wdata[NUM_QCH*QW_W-1:0];
      end
   end

endmodule

// File: rtl/dth_intc.sv
module dth_intc #(
   parameter int NUM_CH = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] set_vec,
   input  logic [NUM_CH-1:0] clr_vec,
   input  logic [NUM_CH-1:0] en_vec,
   output logic [NUM_CH-1:0] pend,
   output logic              irq
);
   always_ff @(posedge clk) begin
      if (!rst_n) pend <= '0;
      else        pend <= set_vec | (pend & ~clr_vec);
   end

   assign irq = |(pend & en_vec);

endmodule

// File: rtl/dma_trig_hub.sv
module dma_trig_hub #(
   parameter int NUM_CH     = 64,
   parameter int NUM_QCH    = 8,
   parameter int DATA_W     = 32,
   parameter int PSET_WORDS = 8,
   parameter int PICK_STYLE = 0,
   localparam int CH_W   = $clog2(NUM_CH),
   localparam int QCH_W  = $clog2(NUM_QCH),
   localparam int QW_W   = $clog2(PSET_WORDS),
   localparam int WORDS  = NUM_CH / DATA_W,
   localparam int WORD_W = (WORDS > 1) ? $clog2(WORDS) : 1,
   localparam int ADDR_W = dth_pkg::GRP_W + WORD_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [DATA_W-1:0]   reg_wdata,
   input  logic [NUM_CH-1:0]   evt_i,
   input  logic                qwr_valid,
   input  logic [QCH_W-1:0]    qwr_ch,
   input  logic [QW_W-1:0]     qwr_word,
   input  logic                cmpl_valid,
   input  logic [CH_W-1:0]     cmpl_code,
   input  logic                cmpl_int_en,
   input  logic                cmpl_chain_en,
   output logic                disp_valid,
   output logic                disp_qdma,
   output logic [CH_W-1:0]     disp_ch,
   output logic [NUM_CH-1:0]   int_pend,
   output logic                irq,
   output logic [NUM_CH-1:0]   miss_err,
   output logic [NUM_QCH-1:0]  qmiss_err,
   output logic                err_irq
);
   import dth_pkg::*;

   // elaboration-time parameter checks
   generate
      if (NUM_CH % DATA_W != 0 || NUM_CH < DATA_W) begin : g_bad_words
         $error("NUM_CH must be a nonzero multiple of DATA_W");
      end
      if (NUM_QCH < 2 || NUM_QCH > NUM_CH) begin : g_bad_qch
         $error("NUM_QCH must lie in 2..NUM_CH");
      end
      if (PSET_WORDS < 2 || (1 << QW_W) != PSET_WORDS) begin : g_bad_pset
         $error("PSET_WORDS must be a power of two, at least 2");
      end
      if (NUM_QCH * QW_W > DATA_W) begin : g_bad_qsel
         $error("quick-channel word selectors do not fit one register word");
      end
      if (PICK_STYLE != PICK_LOOP && PICK_STYLE != PICK_ISOLATE) begin : g_bad_pick
         $error("PICK_STYLE must be 0 or 1");
      end
   endgenerate

   logic [NUM_CH-1:0]       man_trig, evt_en, int_en, int_clr, miss_clr;
   logic [NUM_QCH*QW_W-1:0] qsel;
   logic [NUM_QCH-1:0]      qmiss_clr;

   dth_regs #(
      .NUM_CH(NUM_CH), .NUM_QCH(NUM_QCH), .DATA_W(DATA_W), .PSET_WORDS(PSET_WORDS)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .man_trig(man_trig), .evt_en(evt_en), .int_en(int_en), .int_clr(int_clr),
      .miss_clr(miss_clr), .qsel(qsel), .qmiss_clr(qmiss_clr)
   );

   // completion decode: one code drives both interrupt bit and chain target
   logic [NUM_CH-1:0] code_vec, chain_trig, int_set, sw_trig;
   assign code_vec   = NUM_CH'(1) << cmpl_code;
   assign chain_trig = (cmpl_valid && cmpl_chain_en) ? code_vec : '0;
   assign int_set    = (cmpl_valid && cmpl_int_en)   ? code_vec : '0;
   assign sw_trig    = man_trig | chain_trig;

   // per-channel pending state
   logic [NUM_CH-1:0]  dma_req, dma_take;
   logic [NUM_QCH-1:0] q_req, q_take, q_hit;

   genvar c;
   generate
      for (c = 0; c < NUM_CH; c++) begin : g_dma
         dth_slot u_slot (
            .clk(clk), .rst_n(rst_n),
            .src_gated(evt_i[c]), .src_direct(sw_trig[c]), .gate_en(evt_en[c]),
            .take(dma_take[c]), .miss_clr(miss_clr[c]),
            .req(dma_req[c]), .miss(miss_err[c])
         );
      end
      for (c = 0; c < NUM_QCH; c++) begin : g_qdma
         assign q_hit[c] = qwr_valid && (qwr_ch == QCH_W'(c)) &&
                           (qwr_word == qsel[c*QW_W +: QW_W]);
         dth_slot u_slot (
            .clk(clk), .rst_n(rst_n),
            .src_gated(1'b0), .src_direct(q_hit[c]), .gate_en(1'b0),
            .take(q_take[c]), .miss_clr(qmiss_clr[c]),
            .req(q_req[c]), .miss(qmiss_err[c])
         );
      end
   endgenerate

   // dispatch selection
   logic              d_any, q_any;
   logic [CH_W-1:0]   d_idx;
   logic [QCH_W-1:0]  q_idx;
   logic [NUM_CH-1:0] d_oh;
   logic [NUM_QCH-1:0] q_oh;

   dth_lowest #(.N(NUM_CH), .STYLE(PICK_STYLE)) u_pick_dma (
      .vec(dma_req), .any(d_any), .idx(d_idx), .onehot(d_oh)
   );
   dth_lowest #(.N(NUM_QCH), .STYLE(PICK_STYLE)) u_pick_q (
      .vec(q_req), .any(q_any), .idx(q_idx), .onehot(q_oh)
   );

   assign dma_take = d_oh;
   assign q_take   = d_any ? '0 : q_oh;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         disp_valid <= 1'b0;
         disp_qdma  <= 1'b0;
         disp_ch    <= '0;
      end else begin
         disp_valid <= d_any | q_any;
         disp_qdma  <= ~d_any & q_any;
         disp_ch    <= d_any ? d_idx : CH_W'(q_idx);
      end
   end

   dth_intc #(.NUM_CH(NUM_CH)) u_intc (
      .clk(clk), .rst_n(rst_n), .set_vec(int_set), .clr_vec(int_clr),
      .en_vec(int_en), .pend(int_pend), .irq(irq)
   );

   assign err_irq = (|miss_err) | (|qmiss_err);

endmodule

// File: rtl/dth_checker.sv
module dth_checker #(
   parameter int NUM_CH  = 64,
   parameter int NUM_QCH = 8,
   localparam int CH_W   = $clog2(NUM_CH)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               reg_wr,
   input logic               cmpl_valid,
   input logic               cmpl_int_en,
   input logic [CH_W-1:0]    cmpl_code,
   input logic [NUM_CH-1:0]  dma_req,
   input logic               disp_valid,
   input logic               disp_qdma,
   input logic [CH_W-1:0]    disp_ch,
   input logic [NUM_CH-1:0]  int_pend,
   input logic               irq,
   input logic [NUM_CH-1:0]  miss_err,
   input logic [NUM_QCH-1:0] qmiss_err
);
   // R5: dispatched DMA channel was pending in the selection cycle
   a_r5_was_pending: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid && !disp_qdma |-> (($past(dma_req) >> disp_ch) & NUM_CH'(1)) == NUM_CH'(1));

   // R5: no lower-numbered DMA channel was pending
   a_r5_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid && !disp_qdma |->
         ($past(dma_req) & ((NUM_CH'(1) << disp_ch) - NUM_CH'(1))) == '0);

   // R6: quick channel only when no DMA channel waited
   a_r6_dma_first: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid && disp_qdma |-> $past(dma_req) == '0);

   // R9: completion with interrupt flag sets its bit
   a_r9_int_set: assert property (@(posedge clk) disable iff (!rst_n)
      cmpl_valid && cmpl_int_en |=> ((int_pend >> $past(cmpl_code)) & NUM_CH'(1)) == NUM_CH'(1));

   // R9: no interrupt without a pending bit
   a_r9_irq_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
      int_pend == '0 |-> !irq);

   // R8: missed-trigger bits fall only after a register write
   a_r8_miss_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_wr |=> (miss_err & $past(miss_err)) == $past(miss_err));

   a_r8_qmiss_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_wr |=> (qmiss_err & $past(qmiss_err)) == $past(qmiss_err));

endmodule

bind dma_trig_hub dth_checker #(.NUM_CH(NUM_CH), .NUM_QCH(NUM_QCH)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .cmpl_valid(cmpl_valid),
   .cmpl_int_en(cmpl_int_en), .cmpl_code(cmpl_code), .dma_req(dma_req),
   .disp_valid(disp_valid), .disp_qdma(disp_qdma), .disp_ch(disp_ch),
   .int_pend(int_pend), .irq(irq), .miss_err(miss_err), .qmiss_err(qmiss_err)
);

// File: tb/tb_dma_trig_hub.sv
module tb_dma_trig_hub;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [63:0] evt_i = '0;
   logic        qwr_valid = 1'b0;
   logic [2:0]  qwr_ch = '0;
   logic [2:0]  qwr_word = '0;
   logic        cmpl_valid = 1'b0;
   logic [5:0]  cmpl_code = '0;
   logic        cmpl_int_en = 1'b0;
   logic        cmpl_chain_en = 1'b0;
   logic        disp_valid, disp_qdma, irq, err_irq;
   logic [5:0]  disp_ch;
   logic [63:0] int_pend, miss_err;
   logic [7:0]  qmiss_err;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   dma_trig_hub dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .evt_i(evt_i), .qwr_valid(qwr_valid), .qwr_ch(qwr_ch), .qwr_word(qwr_word),
      .cmpl_valid(cmpl_valid), .cmpl_code(cmpl_code), .cmpl_int_en(cmpl_int_en),
      .cmpl_chain_en(cmpl_chain_en), .disp_valid(disp_valid), .disp_qdma(disp_qdma),
      .disp_ch(disp_ch), .int_pend(int_pend), .irq(irq), .miss_err(miss_err),
      .qmiss_err(qmiss_err), .err_irq(err_irq)
   );

   function automatic logic [3:0] addr(input int grp, input int word);
      return 4'(grp * 2 + word);
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // expected dispatch: v=valid, q=quick flag, ch=channel
   task automatic chk_disp(input string tag, input bit v, input bit q, input int ch);
      logic [63:0] act, exp;
      act = {56'd0, disp_valid, disp_qdma, disp_ch};
      exp = v ? {56'd0, 1'b1, q, 6'(ch)} : 64'd0;
      chk(disp_valid == v && (!v || (disp_qdma == q && disp_ch == 6'(ch))), tag,
          v ? act : {63'd0, disp_valid}, v ? exp : 64'd0);
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic qwr(input int q, input int w);
      qwr_valid = 1'b1; qwr_ch = 3'(q); qwr_word = 3'(w);
      @(negedge clk);
      qwr_valid = 1'b0;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [63:0] exp_pend;
      logic [31:0] sel_word;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(!disp_valid, "R1 disp_valid", {63'd0, disp_valid}, 0);
      chk(int_pend == 0 && miss_err == 0, "R1 pend/miss", int_pend | miss_err, 0);
      chk(qmiss_err == 0 && !irq && !err_irq, "R1 qmiss/irq", {qmiss_err, irq, err_irq}, 0);

      // R2 manual trigger sweep over all channels
      for (int ch = 0; ch < 64; ch++) begin
         wr(addr(0, ch / 32), 32'd1 << (ch % 32));
         @(negedge clk); chk_disp("R2 manual dispatch", 1, 0, ch);
         @(negedge clk); chk_disp("R2 single dispatch", 0, 0, 0);
      end

      // R5 lowest first, one per cycle
      wr(addr(0, 0), (32'd1 << 20) | (32'd1 << 7) | (32'd1 << 3));
      @(negedge clk); chk_disp("R5 order first", 1, 0, 3);
      @(negedge clk); chk_disp("R5 order second", 1, 0, 7);
      @(negedge clk); chk_disp("R5 order third", 1, 0, 20);
      @(negedge clk); chk_disp("R5 order drained", 0, 0, 0);

      // R6 DMA before quick-DMA in the same cycle
      reg_wr = 1'b1; reg_addr = addr(0, 0); reg_wdata = 32'd1 << 9;
      qwr_valid = 1'b1; qwr_ch = 3'd2; qwr_word = 3'd7;
      @(negedge clk);
      reg_wr = 1'b0; qwr_valid = 1'b0;
      @(negedge clk); chk_disp("R6 dma first", 1, 0, 9);
      @(negedge clk); chk_disp("R6 quick after", 1, 1, 2);
      @(negedge clk); chk_disp("R6 drained", 0, 0, 0);

      // R3 event on disabled channel is held, released by enable
      evt_i = 64'd1 << 12;
      @(negedge clk); evt_i = '0;
      @(negedge clk); chk_disp("R3 disabled held", 0, 0, 0);
      @(negedge clk); chk_disp("R3 disabled held", 0, 0, 0);
      wr(addr(1, 0), 32'd1 << 12);
      @(negedge clk); chk_disp("R3 released", 1, 0, 12);
      @(negedge clk); chk_disp("R3 released once", 0, 0, 0);

      // R3 sweep with all events enabled
      wr(addr(1, 0), 32'hFFFF_FFFF);
      wr(addr(1, 1), 32'hFFFF_FFFF);
      for (int ch = 0; ch < 64; ch++) begin
         evt_i = 64'd1 << ch;
         @(negedge clk); evt_i = '0;
         @(negedge clk); chk_disp("R3 event dispatch", 1, 0, ch);
      end
      @(negedge clk); chk_disp("R3 drained", 0, 0, 0);

      // R10 re-arm in dispatch cycle: no miss, dispatched twice
      evt_i = 64'd1 << 7;
      @(negedge clk);
      @(negedge clk); chk_disp("R10 first", 1, 0, 7);
      evt_i = '0;
      @(negedge clk); chk_disp("R10 second", 1, 0, 7);
      chk(miss_err == 0, "R10 no miss", miss_err, 0);
      @(negedge clk); chk_disp("R10 drained", 0, 0, 0);

      // R8 DMA miss on a held (disabled) event
      wr(addr(1, 1), 32'd0);
      evt_i = 64'd1 << 40;
      @(negedge clk);
      @(negedge clk); evt_i = '0;
      chk(miss_err == (64'd1 << 40), "R8 miss set", miss_err, 64'd1 << 40);
      chk(err_irq, "R8 err_irq", {63'd0, err_irq}, 1);
      chk_disp("R8 still held", 0, 0, 0);
      @(negedge clk);
      chk(miss_err == (64'd1 << 40), "R8 miss sticky", miss_err, 64'd1 << 40);
      wr(addr(4, 1), 32'd1 << 8);
      chk(miss_err == 0 && !err_irq, "R8 miss cleared", miss_err, 0);
      wr(addr(1, 1), 32'd1 << 8);
      @(negedge clk); chk_disp("R8 held released", 1, 0, 40);
      @(negedge clk); chk_disp("R8 drained", 0, 0, 0);

      // R7 quick-DMA sweep with reset selector (word 7)
      for (int q = 0; q < 8; q++) begin
         qwr(q, 7);
         @(negedge clk); chk_disp("R7 quick dispatch", 1, 1, q);
      end
      qwr(3, 2);
      chk_disp("R7 other word ignored", 0, 0, 0);
      @(negedge clk); chk_disp("R7 other word ignored", 0, 0, 0);
      sel_word = '0;
      for (int q = 0; q < 8; q++) sel_word[q*3 +: 3] = (q == 3) ? 3'd2 : 3'd7;
      wr(addr(5, 0), sel_word);
      qwr(3, 2);
      @(negedge clk); chk_disp("R7 new selector", 1, 1, 3);
      qwr(3, 7);
      @(negedge clk); chk_disp("R7 old word ignored", 0, 0, 0);

      // R8 / R6 quick miss while DMA channels hold the dispatcher
      wr(addr(0, 0), 32'hFFFF_FFFF);
      qwr_valid = 1'b1; qwr_ch = 3'd1; qwr_word = 3'd7;
      for (int i = 0; i < 32; i++) begin
         @(negedge clk); chk_disp("R6 dma burst", 1, 0, i);
         if (i == 1) qwr_valid = 1'b0;
      end
      @(negedge clk); chk_disp("R6 quick after burst", 1, 1, 1);
      chk(qmiss_err == 8'h02, "R8 quick miss", {56'd0, qmiss_err}, 64'h02);
      @(negedge clk); chk_disp("R8 quick once", 0, 0, 0);
      wr(addr(6, 0), 32'h2);
      chk(qmiss_err == 0 && !err_irq, "R8 quick miss cleared", {56'd0, qmiss_err}, 0);

      // R4 / R9 completion sweep: chain and interrupt
      exp_pend = '0;
      for (int c = 0; c < 64; c++) begin
         cmpl_valid = 1'b1; cmpl_code = 6'(c); cmpl_int_en = 1'b1; cmpl_chain_en = 1'b1;
         @(negedge clk); cmpl_valid = 1'b0;
         exp_pend |= 64'd1 << c;
         chk(int_pend == exp_pend, "R9 int pend", int_pend, exp_pend);
         @(negedge clk); chk_disp("R4 chain dispatch", 1, 0, c);
      end
      chk(!irq, "R9 irq masked", {63'd0, irq}, 0);
      wr(addr(2, 1), 32'd1);
      chk(irq, "R9 irq enabled", {63'd0, irq}, 1);
      wr(addr(3, 1), 32'd1);
      chk(int_pend == ~(64'd1 << 32) && !irq, "R9 w1c", int_pend, ~(64'd1 << 32));
      wr(addr(3, 0), 32'hFFFF_FFFF);
      wr(addr(3, 1), 32'hFFFF_FFFF);
      chk(int_pend == 0, "R9 all cleared", int_pend, 0);

      // R9 set wins over same-cycle clear
      cmpl_valid = 1'b1; cmpl_code = 6'd5; cmpl_int_en = 1'b1; cmpl_chain_en = 1'b0;
      wr(addr(3, 0), 32'd1 << 5);
      cmpl_valid = 1'b0;
      chk(int_pend == (64'd1 << 5), "R9 set wins", int_pend, 64'd1 << 5);
      @(negedge clk); chk_disp("R4 no chain", 0, 0, 0);

      // R4 chain without interrupt
      cmpl_valid = 1'b1; cmpl_code = 6'd6; cmpl_int_en = 1'b0; cmpl_chain_en = 1'b1;
      @(negedge clk); cmpl_valid = 1'b0;
      @(negedge clk); chk_disp("R4 chain only", 1, 0, 6);
      chk(int_pend == (64'd1 << 5), "R9 no int bit", int_pend, 64'd1 << 5);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule